// File: doc/BRIEF.md
# Interrupt and Reset Entry Sequencer

This block sits beside the execution unit of an 8-bit processor and owns every change of control flow that is not caused by an instruction. It keeps a mask of pending maskable interrupt sources and a latched non-maskable request. At each instruction boundary that the core signals, it decides whether an entry is due. If one is, it saves the return state on the stack page through a byte-wide memory port, fetches the vector and hands the core a new program counter, status byte and stack pointer.

The entry takes seven cycles: two internal cycles, three stack writes and two vector reads. The core picks up the results on a one-cycle `load` strobe. After the block reset is released, the same port runs the start-up sequence. That sequence fetches the start address, sets the status to the interrupt-disable flag alone and tells the core to leave its halted state.

Status bit positions used throughout: bit 0 carry, 1 zero, 2 interrupt disable (I), 3 decimal, 4 break (B), 5 unused, 6 overflow, 7 negative.

Top module: `irq_entry_seq`

## Requirements
- R1: After `rst_n` is released, the block reads 0xFFFC and then 0xFFFD. In the cycle after the second read, it pulses `load` and `jam_clr` with `pc_out` = {byte at 0xFFFD, byte at 0xFFFC}, `p_out` = 0x04 and `s_out` = `s_in`.
- R2: An entry writes three bytes, at 0x0100+S, 0x0100+S-1 and 0x0100+S-2, where S is `s_in` at acceptance. The stack offset wraps modulo 256. `s_out` is S-3 modulo 256.
- R3: The bytes written are, in order, the PC high byte, the PC low byte, and `p_in` with bit 4 cleared and bit 5 set.
- R4: The NMI vector is read from 0xFFFA then 0xFFFB, and the IRQ vector from 0xFFFE then 0xFFFF, low byte first. `pc_out` is {high, low}.
- R5: Between acceptance and `load` there are exactly 7 cycles with `busy` high: two with no memory request, three writes, then two reads. `load` is high for the one cycle after `busy` falls.
- R6: When an NMI and an IRQ are both pending at a boundary, the NMI entry is performed.
- R7: An IRQ is taken only if `i_prev` is 0 at the boundary. An NMI is taken regardless of `i_prev`.
- R8: While `jammed` is 1, a boundary starts no entry. The attempt still consumes the NMI request and the one-shot IRQ source.
- R9: `irq_pend` bit k is set by `irq_set[k]` and cleared by `irq_clr[k]`, with clear winning when both are high. Bits other than the one-shot bit stay set across an entry, so a source that is not cleared is taken again at a later boundary.
- R10: An attempted entry (a boundary with any request pending while idle) clears the NMI latch and `irq_pend[ONESHOT]`, whether or not an entry is made.
- R11: After an entry, `p_out` is `p_in` with bit 4 cleared, and with bit 2 set for an IRQ entry. The NMI entry leaves bit 2 as it was.
- R12: A boundary while `busy` is ignored. An NMI or IRQ request arriving during an entry stays pending and is served at the next idle boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release starts the start-up fetch |
| boundary | input | 1 | Core is between instructions and may be diverted |
| nmi_req | input | 1 | Non-maskable request pulse, latched |
| irq_set | input | NSRC | Per-source IRQ set |
| irq_clr | input | NSRC | Per-source IRQ clear |
| i_prev | input | 1 | I flag as it stood before the previous instruction |
| jammed | input | 1 | Core is halted |
| pc_in | input | 16 | Return address to save |
| p_in | input | 8 | Status to save |
| s_in | input | 8 | Stack pointer at acceptance |
| mem_rdata | input | 8 | Read data, sampled at the end of the request cycle |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Access address |
| mem_wdata | output | 8 | Write data |
| busy | output | 1 | Sequence in progress |
| load | output | 1 | One-cycle strobe: core takes pc_out, p_out, s_out |
| jam_clr | output | 1 | One-cycle strobe with the start-up load: leave halted state |
| pc_out | output | 16 | New program counter |
| p_out | output | 8 | New status |
| s_out | output | 8 | New stack pointer |
| irq_pend | output | NSRC | Pending IRQ source mask |

## Verification
The bound checker watches on every cycle that writes stay on the stack page, that reads hit only the vector area, and that the third consecutive write carries B clear and the unused bit set. It also checks that `load` follows every fall of `busy`, that a masked or jammed boundary starts nothing, and that an accepted entry leaves neither the NMI latch nor the one-shot source pending. The exact byte order and values, the vector chosen under NMI/IRQ contention, level re-entry, stack wrap and requests arriving mid-sequence are only shown by the bench's scenarios against its reference model.

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int         NSRC       = 4,
  parameter int         ONESHOT    = 0,
  parameter logic [7:0] STACK_PAGE = 8'h01
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            boundary,
  input  logic            nmi_req,
  input  logic [NSRC-1:0] irq_set,
  input  logic [NSRC-1:0] irq_clr,
  input  logic            i_prev,
  input  logic            jammed,
  input  logic [15:0]     pc_in,
  input  logic [7:0]      p_in,
  input  logic [7:0]      s_in,
  input  logic [7:0]      mem_rdata,
  output logic            mem_req,
  output logic            mem_we,
  output logic [15:0]     mem_addr,
  output logic [7:0]      mem_wdata,
  output logic            busy,
  output logic            load,
  output logic            jam_clr,
  output logic [15:0]     pc_out,
  output logic [7:0]      p_out,
  output logic [7:0]      s_out,
  output logic [NSRC-1:0] irq_pend
);
  localparam logic [15:0] VEC_NMI = 16'hFFFA;
  localparam logic [15:0] VEC_RST = 16'hFFFC;
  localparam logic [15:0] VEC_IRQ = 16'hFFFE;
  localparam logic [7:0]  FLG_I   = 8'h04;
  localparam logic [7:0]  FLG_B   = 8'h10;
  localparam logic [7:0]  FLG_U   = 8'h20;
  localparam logic [NSRC-1:0] ONE_MASK = NSRC'(1) << ONESHOT;

  typedef enum logic [3:0] {
    ST_RLO, ST_RHI, ST_IDLE, ST_D1, ST_D2, ST_PH, ST_PL, ST_PP, ST_VL, ST_VH
  } st_t;

  st_t         st;
  logic [7:0]  sp, pst, vlo;
  logic [15:0] pcs;
  logic        is_irq, nmi_pend;

  wire            eff_nmi  = nmi_pend | nmi_req;
  wire [NSRC-1:0] eff_irq  = (irq_pend | irq_set) & ~irq_clr;
  wire            attempt  = (st == ST_IDLE) && boundary && (eff_nmi || (|eff_irq));
  wire            take_nmi = attempt && eff_nmi && !jammed;
  wire            take_irq = attempt && !eff_nmi && !i_prev && !jammed;
  wire [15:0]     vec_base = is_irq ? VEC_IRQ : VEC_NMI;

  assign busy    = (st != ST_IDLE);
  assign mem_we  = (st == ST_PH) || (st == ST_PL) || (st == ST_PP);
  assign mem_req = mem_we || (st == ST_VL) || (st == ST_VH) ||
                   (st == ST_RLO) || (st == ST_RHI);

  always_comb begin
    mem_addr  = 16'h0000;
    mem_wdata = 8'h00;
    case (st)
      ST_RLO: mem_addr = VEC_RST;
      ST_RHI: mem_addr = VEC_RST | 16'h0001;
      ST_PH: begin mem_addr = {STACK_PAGE, sp}; mem_wdata = pcs[15:8]; end
      ST_PL: begin mem_addr = {STACK_PAGE, sp}; mem_wdata = pcs[7:0]; end
      ST_PP: begin mem_addr = {STACK_PAGE, sp}; mem_wdata = (pst & ~FLG_B) | FLG_U; end
      ST_VL: mem_addr = vec_base;
      ST_VH: mem_addr = vec_base | 16'h0001;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_RLO;
      sp       <= 8'h00;
      pst      <= 8'h00;
      vlo      <= 8'h00;
      pcs      <= 16'h0000;
      is_irq   <= 1'b0;
      nmi_pend <= 1'b0;
      irq_pend <= '0;
      load     <= 1'b0;
      jam_clr  <= 1'b0;
      pc_out   <= 16'h0000;
      p_out    <= FLG_I;
      s_out    <= 8'h00;
    end else begin
      load     <= 1'b0;
      jam_clr  <= 1'b0;
      nmi_pend <= attempt ? 1'b0 : eff_nmi;
      irq_pend <= attempt ? (eff_irq & ~ONE_MASK) : eff_irq;
      case (st)
        ST_RLO: begin vlo <= mem_rdata; st <= ST_RHI; end
        ST_RHI: begin
          pc_out  <= {mem_rdata, vlo};
          p_out   <= FLG_I;
          s_out   <= s_in;
          load    <= 1'b1;
          jam_clr <= 1'b1;
          st      <= ST_IDLE;
        end
        ST_IDLE: if (take_nmi || take_irq) begin
          pcs    <= pc_in;
          pst    <= p_in;
          sp     <= s_in;
          is_irq <= take_irq;
          st     <= ST_D1;
        end
        ST_D1: st <= ST_D2;
        ST_D2: st <= ST_PH;
        ST_PH: begin sp <= sp - 8'd1; st <= ST_PL; end
        ST_PL: begin sp <= sp - 8'd1; st <= ST_PP; end
        ST_PP: begin sp <= sp - 8'd1; st <= ST_VL; end
        ST_VL: begin vlo <= mem_rdata; st <= ST_VH; end
        ST_VH: begin
          pc_out <= {mem_rdata, vlo};
          p_out  <= (pst & ~FLG_B) | (is_irq ? FLG_I : 8'h00);
          s_out  <= sp;
          load   <= 1'b1;
          st     <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

module irq_entry_seq_chk #(
  parameter int         NSRC       = 4,
  parameter int         ONESHOT    = 0,
  parameter logic [7:0] STACK_PAGE = 8'h01
) (
  input logic            clk,
  input logic            rst_n,
  input logic            boundary,
  input logic            nmi_req,
  input logic            nmi_pend,
  input logic            i_prev,
  input logic            jammed,
  input logic [NSRC-1:0] irq_pend,
  input logic            mem_req,
  input logic            mem_we,
  input logic [15:0]     mem_addr,
  input logic [7:0]      mem_wdata,
  input logic            busy,
  input logic            load,
  input logic            jam_clr
);
  a_r2_write_on_stack: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_req && mem_addr[15:8] == STACK_PAGE));
  a_r4_read_vectors: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (mem_addr[15:3] == 13'h1FFF));
  a_r3_status_push: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we) && $past(mem_we, 2)) |-> (mem_wdata[5] && !mem_wdata[4]));
  a_r5_load_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> load);
  a_r5_load_idle: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy);
  a_r1_jamclr_with_load: assert property (@(posedge clk) disable iff (!rst_n)
    jam_clr |-> load);
  a_r7_masked_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && boundary && i_prev && !nmi_req && !nmi_pend) |=> !busy);
  a_r8_jammed: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && jammed) |=> !busy);
  a_r10_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!nmi_pend && !irq_pend[ONESHOT]));
endmodule

bind irq_entry_seq irq_entry_seq_chk #(
  .NSRC(NSRC), .ONESHOT(ONESHOT), .STACK_PAGE(STACK_PAGE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .boundary(boundary), .nmi_req(nmi_req),
  .nmi_pend(nmi_pend), .i_prev(i_prev), .jammed(jammed), .irq_pend(irq_pend),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .busy(busy), .load(load), .jam_clr(jam_clr)
);

// File: tb/test_irq_entry_seq.sv
module test_irq_entry_seq;
  localparam int NSRC = 4;
  localparam int ONE  = 0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic boundary = 1'b0, nmi_req = 1'b0, i_prev = 1'b0, jammed = 1'b0;
  logic [NSRC-1:0] irq_set = '0, irq_clr = '0;
  logic [15:0] pc_in = 16'h0000;
  logic [7:0]  p_in = 8'h00, s_in = 8'hFD;
  logic [7:0]  mem_rdata;
  logic mem_req, mem_we, busy, load, jam_clr;
  logic [15:0] mem_addr, pc_out;
  logic [7:0]  mem_wdata, p_out, s_out;
  logic [NSRC-1:0] irq_pend;

  always #10 clk = ~clk;

  function automatic logic [7:0] vec(input logic [15:0] a);
    case (a)
      16'hFFFA: return 8'h34;
      16'hFFFB: return 8'h12;
      16'hFFFC: return 8'h00;
      16'hFFFD: return 8'hC0;
      16'hFFFE: return 8'h78;
      16'hFFFF: return 8'h56;
      default:  return 8'hEE;
    endcase
  endfunction
  assign mem_rdata = vec(mem_addr);

  irq_entry_seq #(.NSRC(NSRC), .ONESHOT(ONE)) i_irq_entry_seq (
    .clk(clk), .rst_n(rst_n), .boundary(boundary), .nmi_req(nmi_req),
    .irq_set(irq_set), .irq_clr(irq_clr), .i_prev(i_prev), .jammed(jammed),
    .pc_in(pc_in), .p_in(p_in), .s_in(s_in), .mem_rdata(mem_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .busy(busy), .load(load), .jam_clr(jam_clr), .pc_out(pc_out), .p_out(p_out),
    .s_out(s_out), .irq_pend(irq_pend)
  );

  int checks = 0, failures = 0, loads = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model: op = {req, we, addr[15:0], data[7:0]}
  logic [25:0] q[$];
  logic        m_npend, m_load, m_jc;
  logic [NSRC-1:0] m_ipend;
  logic [15:0] m_pc;
  logic [7:0]  m_p, m_s, m_lo, sv_p, sv_s;
  int          kind;

  function automatic logic [25:0] rd(input logic [15:0] a);
    return {1'b1, 1'b0, a, 8'h00};
  endfunction
  function automatic logic [25:0] wr(input logic [7:0] s, input logic [7:0] d);
    return {1'b1, 1'b1, 8'h01, s, d};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      q.push_back(rd(16'hFFFC));
      q.push_back(rd(16'hFFFD));
      kind = 0; m_npend = 0; m_ipend = '0; m_load = 0; m_jc = 0;
      m_pc = 16'h0000; m_p = 8'h04; m_s = 8'h00; m_lo = 8'h00;
    end else begin
      logic en;
      logic [NSRC-1:0] ei;
      en = m_npend | nmi_req;
      ei = (m_ipend | irq_set) & ~irq_clr;
      m_load = 0; m_jc = 0;
      if (q.size() != 0) begin
        logic [25:0] op;
        op = q.pop_front();
        m_npend = en; m_ipend = ei;
        if (op[25] && !op[24]) begin
          if (q.size() != 0) m_lo = vec(op[23:8]);
          else begin
            m_pc = {vec(op[23:8]), m_lo};
            m_load = 1; loads++;
            if (kind == 0) begin m_p = 8'h04; m_s = s_in; m_jc = 1; end
            else begin
              m_p = (sv_p & ~8'h10) | (kind == 2 ? 8'h04 : 8'h00);
              m_s = sv_s - 8'd3;
            end
          end
        end
      end else if (boundary && (en || ei != '0)) begin
        m_npend = 0;
        m_ipend = ei & ~(NSRC'(1) << ONE);
        if (!jammed && (en || !i_prev)) begin
          logic [15:0] v;
          kind = en ? 1 : 2;
          v = en ? 16'hFFFA : 16'hFFFE;
          sv_p = p_in; sv_s = s_in;
          q.push_back(26'd0);
          q.push_back(26'd0);
          q.push_back(wr(s_in, pc_in[15:8]));
          q.push_back(wr(s_in - 8'd1, pc_in[7:0]));
          q.push_back(wr(s_in - 8'd2, (p_in & ~8'h10) | 8'h20));
          q.push_back(rd(v));
          q.push_back(rd(v | 16'h0001));
        end
      end else begin
        m_npend = en; m_ipend = ei;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic [25:0] e;
      e = (q.size() != 0) ? q[0] : 26'd0;
      chk(busy == (q.size() != 0), "R5 busy", 32'(busy), 32'(q.size() != 0));
      chk(mem_req == e[25] && mem_we == e[24], "R2 R4 bus request kind",
          {30'd0, mem_req, mem_we}, {30'd0, e[25], e[24]});
      if (e[25]) chk(mem_addr == e[23:8], "R2 R4 address", 32'(mem_addr), 32'(e[23:8]));
      if (e[24]) chk(mem_wdata == e[7:0], "R3 write data", 32'(mem_wdata), 32'(e[7:0]));
      chk(load == m_load, "R5 load strobe", 32'(load), 32'(m_load));
      chk(jam_clr == m_jc, "R1 jam_clr", 32'(jam_clr), 32'(m_jc));
      chk(pc_out == m_pc, "R4 pc_out", 32'(pc_out), 32'(m_pc));
      chk(p_out == m_p, "R11 p_out", 32'(p_out), 32'(m_p));
      chk(s_out == m_s, "R2 s_out", 32'(s_out), 32'(m_s));
      chk(irq_pend == m_ipend, "R9 R10 irq_pend", 32'(irq_pend), 32'(m_ipend));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bnd;
    boundary = 1'b1; tick(1); boundary = 1'b0;
  endtask

  task automatic wait_idle;
    int guard = 0;
    while (busy && guard < 50) begin tick(1); guard++; end
    tick(1);
  endtask

  initial begin
    int base;
    tick(2);
    rst_n = 1'b1;
    tick(4);
    chk(pc_out == 16'hC000 && p_out == 8'h04, "R1 start-up vector", 32'(pc_out), 32'hC000);

    // R11 R4 R3: IRQ from source 1, B set in p_in
    pc_in = 16'h1234; p_in = 8'hD3; s_in = 8'hFD; i_prev = 1'b0;
    irq_set = 4'b0010; tick(1); irq_set = '0;
    bnd(); wait_idle();
    chk(pc_out == 16'h5678 && p_out == 8'hC7, "R11 irq entry result", {pc_out, 8'h0, p_out}, 32'h5678_00C7);

    // R9: level source still pending -> taken again
    chk(irq_pend == 4'b0010, "R9 level stays", 32'(irq_pend), 32'h2);
    base = loads; pc_in = 16'h2000; p_in = 8'h00; bnd(); wait_idle();
    chk(loads == base + 1, "R9 retaken", loads, base + 1);
    irq_clr = 4'b0010; tick(1); irq_clr = '0;

    // R7: masked IRQ
    base = loads; i_prev = 1'b1; irq_set = 4'b0100; tick(1); irq_set = '0;
    bnd(); tick(9);
    chk(loads == base, "R7 masked irq not taken", loads, base);
    // R7: NMI ignores mask; R6: NMI beats IRQ
    nmi_req = 1'b1; tick(1); nmi_req = 1'b0;
    i_prev = 1'b0; p_in = 8'h01; bnd(); wait_idle();
    chk(pc_out == 16'h1234 && p_out == 8'h01, "R6 nmi preferred", {pc_out, 8'h0, p_out}, 32'h1234_0001);
    irq_clr = 4'b0100; tick(1); irq_clr = '0;

    // R8 R10: jammed consumes NMI and one-shot without entry
    base = loads; jammed = 1'b1; nmi_req = 1'b1; irq_set = 4'b0001; tick(1);
    nmi_req = 1'b0; irq_set = '0; bnd(); tick(9);
    jammed = 1'b0; bnd(); tick(9);
    chk(loads == base, "R8 jammed no entry", loads, base);
    chk(irq_pend == 4'b0000, "R10 one-shot consumed", 32'(irq_pend), 32'h0);

    // R10: one-shot taken once
    base = loads; irq_set = 4'b0001; tick(1); irq_set = '0;
    bnd(); wait_idle(); bnd(); tick(9);
    chk(loads == base + 1, "R10 one-shot single entry", loads, base + 1);

    // R2: stack wrap
    s_in = 8'h01; pc_in = 16'hABCD; p_in = 8'hFF;
    nmi_req = 1'b1; boundary = 1'b1; tick(1); nmi_req = 1'b0; boundary = 1'b0;
    wait_idle();
    chk(s_out == 8'hFE, "R2 stack wrap", 32'(s_out), 32'hFE);

    // R12: boundary during busy ignored, NMI arriving mid-entry pending
    base = loads; s_in = 8'h80; irq_set = 4'b1000; tick(1); irq_set = '0;
    bnd(); tick(2); nmi_req = 1'b1; boundary = 1'b1; tick(1); nmi_req = 1'b0; boundary = 1'b0;
    wait_idle();
    chk(loads == base + 1, "R12 boundary in busy ignored", loads, base + 1);
    bnd(); wait_idle();
    chk(pc_out == 16'h1234, "R12 late nmi served", 32'(pc_out), 32'h1234);
    irq_clr = 4'b1000; tick(1); irq_clr = '0;

    // R9: set and clear together -> clear wins
    irq_set = 4'b0110; irq_clr = 4'b0100; tick(1); irq_set = '0; irq_clr = '0;
    tick(1);
    chk(irq_pend == 4'b0010, "R9 clear wins", 32'(irq_pend), 32'h2);
    irq_clr = 4'b0010; tick(2); irq_clr = '0;

    // R1: second reset
    rst_n = 1'b0; tick(2); rst_n = 1'b1; s_in = 8'h55; tick(4);
    chk(pc_out == 16'hC000 && s_out == 8'h55, "R1 reset reload", 32'(s_out), 32'h55);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule